// File: doc/BRIEF.md
# Command-Driven SPI Master with Shared Byte Buffer

This block is a register-mapped SPI master. Software fills a small buffer of byte slots and sets up a configuration word, then writes a command word. The command word starts one transaction. It names one of four chip selects and gives two counts: how many bytes are driven out of the buffer, and how many bytes are clocked in total. Bytes past the transmit count are receive-only, and the master drives its data line low for them. Each received byte overwrites the slot it came from. A busy bit in the status word stays high until the last byte has finished.

The serial clock is derived from the system clock. Its period is twice the configured divider, in system cycles. Clock polarity and phase come from two configuration bits. Bit order, chip-select polarity and a 3-wire mode that shares a single data line are also set in the configuration word. A hold flag in the command keeps the chip select asserted after the transaction. This lets several commands form one frame on the wire.

Top module: `spim_cmdbuf`

## Requirements
- R1: After reset, the status busy bit (status word bit 0) reads 0 and the configuration reads 0. All four chip-select output enables are 0, every chip-select line sits at its inactive level 1, sclk is 0 and mosi_oe is 1.
- R2: The register map is:
  - configuration at address 0x00, which reads back its defined fields;
  - status at 0x08, with busy in bit 0;
  - command at 0x10;
  - nine byte slots at 0x80 + 8*i, each read and written in bits 7:0.
- R3: A configuration divider field (bits 28:16) of value D gives a serial clock period of 2*D system cycles, and D = 0 acts as D = 1. Busy rises at the clock edge that takes the command write and stays high for exactly 16*D*T cycles, where T is the effective total count. Exactly 8*T sampling edges occur.
- R4: Configuration bit 5 is the phase bit CPHA, and the polarity is CPOL = bit 4 XOR bit 5. sclk idles at CPOL. Data changes at the start of each bit and is sampled at mid-bit, on the sclk edge that leaves the level (bit 4) for its complement.
- R5: Configuration bit 2 selects LSB-first shifting for both directions. When it is 0, bytes are shifted MSB first.
- R6: In the command word, bits 3:0 give the total count T and bits 11:8 give the transmit count X. T = 0 acts as 1 and T > 9 acts as 9, and X is clamped to T. Bytes 0..X-1 carry slots 0..X-1 on mosi, and later bytes are sent as zeros.
- R7: Byte i received on sdi is written into slot i for i < T. Slots at index T and above are left unchanged.
- R8: Configuration bits 15:12 enable the four chip-select outputs, one bit each. Bit 1 set makes the chip select active-high. Command bits 17:16 pick the chip select. The selected line is at its active level while busy. At the end of the transaction the line is released unless command bit 20 (hold) was set, in which case it stays active until the next command ends. At most one line is ever active.
- R9: Any register write made while busy is high is ignored. This covers the command, the configuration and the slots.
- R10: With configuration bit 3 (3-wire) set, mosi_oe is high only during transmit bytes and low during receive-only bytes and while idle. With bit 3 clear, mosi_oe is always high.
- R11: Writing 0 to the configuration register disables all chip-select outputs and releases a held chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sclk | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for the data line |
| sdi | input | 1 | Serial data in (the shared line in 3-wire mode) |
| cs_o | output | 4 | Chip-select levels |
| cs_oe | output | 4 | Chip-select output enables |

## Verification
A command write is taken at one rising edge, and busy reads high at the falling edge that follows. The bench polls the status word at every falling edge and counts the cycles until busy falls; that count must equal 16*D*T exactly. The slave model reacts to sclk edges rather than to clock cycles, because the design samples sdi at the same system edge where sclk moves to its mid-bit level. The model therefore updates sdi just after that edge, and mosi has been stable since the start of the bit. Slot contents and chip-select levels are read only after busy has dropped. The chip-select levels during a transaction are captured at the first sampling edge.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DIV_W  = 13;
  localparam int CS_N   = 4;
  localparam int CNT_W  = 4;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [DIV_W-1:0] clkdiv;
    logic [CS_N-1:0]  cs_en;
    logic             late;
    logic             idle_lo;
    logic             three_wire;
    logic             lsb_first;
    logic             cs_high;
  } cfg_t;

  function automatic cfg_t cfg_unpack(input logic [31:0] w);
    cfg_t c;
    c.clkdiv     = w[16 +: DIV_W];
    c.cs_en      = w[12 +: CS_N];
    c.late       = w[5];
    c.idle_lo    = w[4];
    c.three_wire = w[3];
    c.lsb_first  = w[2];
    c.cs_high    = w[1];
    return c;
  endfunction

  function automatic logic [31:0] cfg_pack(input cfg_t c);
    logic [31:0] w;
    w = '0;
    w[16 +: DIV_W] = c.clkdiv;
    w[12 +: CS_N]  = c.cs_en;
    w[5] = c.late;
    w[4] = c.idle_lo;
    w[3] = c.three_wire;
    w[2] = c.lsb_first;
    w[1] = c.cs_high;
    return w;
  endfunction

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  function automatic logic [CNT_W-1:0] clamp_tot(input logic [CNT_W-1:0] t,
                                                 input logic [CNT_W-1:0] maxv);
    if (t == '0) return CNT_W'(1);
    if (t > maxv) return maxv;
    return t;
  endfunction

  function automatic logic [CNT_W-1:0] clamp_tx(input logic [CNT_W-1:0] x,
                                                input logic [CNT_W-1:0] tot);
    return (x > tot) ? tot : x;
  endfunction

  // polarity: idle level of the serial clock
  function automatic logic sclk_idle(input cfg_t c);
    return c.idle_lo ^ c.late;
  endfunction
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = run && (cnt_q == div - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_val,
  input  logic          tick,
  input  logic          lsb_first,
  input  logic          sdi,
  output logic          mosi_bit,
  output logic          half,
  output logic          sample_evt,
  output logic          byte_end,
  output logic [BW-1:0] rx_byte
);
  localparam int IW = $clog2(BW);
  logic [IW-1:0] bit_q;
  logic [BW-1:0] tx_q, rx_q;
  logic          half_q, shift_evt;

  assign sample_evt = tick && !half_q;
  assign shift_evt  = tick && half_q;
  assign byte_end   = shift_evt && (bit_q == IW'(BW-1));
  assign mosi_bit   = lsb_first ? tx_q[0] : tx_q[BW-1];
  assign half       = half_q;
  assign rx_byte    = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0; half_q <= 1'b0; tx_q <= '0; rx_q <= '0;
    end else if (load) begin
      tx_q <= load_val; bit_q <= '0; half_q <= 1'b0;
    end else begin
      if (sample_evt) begin
        half_q <= 1'b1;
        rx_q   <= lsb_first ? {sdi, rx_q[BW-1:1]} : {rx_q[BW-2:0], sdi};
      end
      if (shift_evt) begin
        half_q <= 1'b0;
        bit_q  <= bit_q + 1'b1;
        tx_q   <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
      end
    end
  end
endmodule

// File: rtl/spim_csctl.sv
module spim_csctl #(
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  en,
  input  logic          cs_high,
  input  logic          active,
  input  logic [SW-1:0] sel,
  output logic [N-1:0]  cs_o,
  output logic [N-1:0]  cs_oe
);
  for (genvar g = 0; g < N; g++) begin : g_cs
    assign cs_o[g]  = (active && sel == SW'(g)) ? cs_high : ~cs_high;
    assign cs_oe[g] = en[g];
  end
endmodule

// File: rtl/spim_cmdbuf.sv
module spim_cmdbuf
  import spim_pkg::*;
#(
  parameter int SLOTS  = 9,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              sdi,
  output logic [CS_N-1:0]   cs_o,
  output logic [CS_N-1:0]   cs_oe
);
  localparam int SEL_W = $clog2(CS_N);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] STS_A  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(8'h80);
  localparam logic [CNT_W-1:0]  MAXN   = CNT_W'(SLOTS);

  cfg_t                cfg_q;
  logic                busy_q, held_q, leave_q;
  logic [SEL_W-1:0]    sel_q;
  logic [CNT_W-1:0]    tot_q, txn_q, byte_q, next_idx;
  logic [BYTE_W-1:0]   slot_q [SLOTS];
  logic [BYTE_W-1:0]   next_tx, first_tx, rx_byte, mosi_load;
  logic [ADDR_W-1:0]   soff;
  logic [CNT_W-1:0]    cmd_tot, cmd_tx;
  logic wr_ok, cfg_hit, cmd_hit, slot_hit, tick, half, sample_evt, byte_end;
  logic last_byte, done_evt, tx_active, idle_lvl, mosi_bit, load;

  // decode
  assign wr_ok    = reg_wr && !busy_q;
  assign soff     = reg_addr - SLOT_A;
  assign slot_hit = (reg_addr >= SLOT_A) && (soff[2:0] == 3'b0) &&
                    (soff[ADDR_W-1:3] < (ADDR_W-3)'(SLOTS));
  assign cfg_hit  = wr_ok && reg_addr == CFG_A;
  assign cmd_hit  = wr_ok && reg_addr == CMD_A;
  assign cmd_tot  = clamp_tot(reg_wdata[3:0], MAXN);
  assign cmd_tx   = clamp_tx(reg_wdata[11:8], cmd_tot);

  // sequencing
  assign next_idx  = byte_q + 1'b1;
  assign last_byte = (byte_q == tot_q - 1'b1);
  assign done_evt  = byte_end && last_byte;
  assign tx_active = busy_q && (byte_q < txn_q);
  assign first_tx  = (cmd_tx != '0) ? slot_q[0] : '0;
  assign load      = cmd_hit || (byte_end && !last_byte);
  assign mosi_load = cmd_hit ? first_tx : next_tx;

  always_comb begin
    next_tx = '0;
    for (int i = 0; i < SLOTS; i++)
      if (next_idx == CNT_W'(i) && next_idx < txn_q) next_tx = slot_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; busy_q <= 1'b0; held_q <= 1'b0; leave_q <= 1'b0;
      sel_q <= '0; tot_q <= '0; txn_q <= '0; byte_q <= '0;
    end else begin
      if (cfg_hit) begin
        cfg_q <= cfg_unpack(reg_wdata);
        if (reg_wdata == '0) held_q <= 1'b0;
      end
      if (cmd_hit) begin
        busy_q  <= 1'b1;
        tot_q   <= cmd_tot;
        txn_q   <= cmd_tx;
        sel_q   <= reg_wdata[16 +: SEL_W];
        leave_q <= reg_wdata[20];
        byte_q  <= '0;
      end
      if (byte_end) begin
        if (last_byte) begin
          busy_q <= 1'b0;
          held_q <= leave_q;
        end else begin
          byte_q <= next_idx;
        end
      end
    end
  end

  // buffer: software writes when idle, received bytes while busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (wr_ok && slot_hit && soff[ADDR_W-1:3] == (ADDR_W-3)'(i))
          slot_q[i] <= reg_wdata[BYTE_W-1:0];
        if (byte_end && byte_q == CNT_W'(i))
          slot_q[i] <= rx_byte;
      end
    end
  end

  spim_clkgen #(.W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .div(eff_div(cfg_q.clkdiv)), .tick(tick)
  );

  spim_shifter #(.BW(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(mosi_load), .tick(tick),
    .lsb_first(cfg_q.lsb_first), .sdi(sdi), .mosi_bit(mosi_bit), .half(half),
    .sample_evt(sample_evt), .byte_end(byte_end), .rx_byte(rx_byte)
  );

  spim_csctl #(.N(CS_N)) u_cs (
    .en(cfg_q.cs_en), .cs_high(cfg_q.cs_high), .active(busy_q || held_q),
    .sel(sel_q), .cs_o(cs_o), .cs_oe(cs_oe)
  );

  assign idle_lvl = sclk_idle(cfg_q);
  assign sclk     = busy_q ? (idle_lvl ^ half ^ cfg_q.late) : idle_lvl;
  assign mosi_o   = tx_active && mosi_bit;
  assign mosi_oe  = !cfg_q.three_wire || tx_active;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CFG_A) reg_rdata = cfg_pack(cfg_q);
    if (reg_addr == STS_A) reg_rdata = {31'b0, busy_q};
    for (int i = 0; i < SLOTS; i++)
      if (slot_hit && soff[ADDR_W-1:3] == (ADDR_W-3)'(i))
        reg_rdata = {{(32-BYTE_W){1'b0}}, slot_q[i]};
  end
endmodule

// File: rtl/spim_cmdbuf_chk.sv
module spim_cmdbuf_chk #(
  parameter int CNT_W = 4,
  parameter int N     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             tick,
  input logic             sclk,
  input logic [N-1:0]     cs_o,
  input logic             cs_high,
  input logic             three_wire,
  input logic             mosi_oe,
  input logic             done_evt,
  input logic [CNT_W-1:0] tot,
  input logic [CNT_W-1:0] byte_idx
);
  // R8
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_high ? cs_o : ~cs_o));

  // R4
  sclk_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(sclk));

  // R10
  idle_line_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (three_wire && !busy) |-> !mosi_oe);

  // R9
  cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tot));

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done_evt));

  // R7
  byte_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (byte_idx < tot));
endmodule

bind spim_cmdbuf spim_cmdbuf_chk #(.CNT_W(spim_pkg::CNT_W), .N(spim_pkg::CS_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .tick(tick), .sclk(sclk),
  .cs_o(cs_o), .cs_high(cfg_q.cs_high), .three_wire(cfg_q.three_wire),
  .mosi_oe(mosi_oe), .done_evt(done_evt), .tot(tot_q), .byte_idx(byte_q)
);

// File: tb/spim_cmdbuf_tb.sv
module spim_cmdbuf_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, reg_wr, sdi, sclk, mosi_o, mosi_oe;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [3:0]  cs_o, cs_oe;

  spim_cmdbuf u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .sdi(sdi), .cs_o(cs_o), .cs_oe(cs_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0]  m_slot [9];
  logic [31:0] m_cfg;
  logic [7:0]  rxb [9];
  bit mon_on = 0, mon_mid = 0;
  int nbits;
  bit cap [72];
  bit cap_oe [72];
  bit mbits [73];
  logic [3:0] cs_run, oe_run;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // slave model: sample mosi and advance sdi at each mid-bit edge
  always @(sclk) begin
    if (mon_on && sclk == mon_mid) begin
      if (nbits == 0) begin cs_run = cs_o; oe_run = cs_oe; end
      if (nbits < 72) begin cap[nbits] = mosi_o; cap_oe[nbits] = mosi_oe; end
      nbits++;
      if (nbits < 73) sdi = mbits[nbits];
    end
  end

  function automatic int eff_div(input int d); return (d == 0) ? 1 : d; endfunction
  function automatic int tot_of(input int t);
    return (t == 0) ? 1 : ((t > 9) ? 9 : t);
  endfunction
  function automatic int min2(input int a, input int b); return (a < b) ? a : b; endfunction
  function automatic logic [31:0] mkcfg(input int div, input logic [3:0] en, input bit late,
                                        input bit idle, input bit tw, input bit lsb, input bit hi);
    return (32'(div) << 16) | (32'(en) << 12) | (32'(late) << 5) | (32'(idle) << 4) |
           (32'(tw) << 3) | (32'(lsb) << 2) | (32'(hi) << 1);
  endfunction
  function automatic logic [3:0] cs_exp(input bit act, input int id, input bit hi);
    logic [3:0] v;
    for (int g = 0; g < 4; g++) v[g] = (act && g == id) ? hi : ~hi;
    return v;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_cfg(input logic [31:0] d);
    logic [31:0] r;
    wr(8'h00, d); m_cfg = d;
    rd(8'h00, r);
    chk(r == d, "R2", "config readback", r, d);
  endtask

  task automatic fill_slots();
    for (int i = 0; i < 9; i++) begin
      m_slot[i] = 8'($urandom);
      wr(8'h80 + 8'(8 * i), {24'b0, m_slot[i]});
    end
  endtask

  task automatic run(input int traw, input int xraw, input int id, input bit leave, input bit poke);
    int tot, tx, div, cyc, bi;
    bit lsb, tw, hi, ok_tx, ok_oe;
    logic [7:0] sent;
    logic [31:0] r;
    tot = tot_of(traw); tx = min2(xraw, tot);
    div = eff_div(int'(m_cfg[28:16])); lsb = m_cfg[2]; tw = m_cfg[3]; hi = m_cfg[1];
    for (int i = 0; i < 9; i++) rxb[i] = 8'($urandom);
    for (int i = 0; i < tot; i++)
      for (int j = 0; j < 8; j++) mbits[i*8+j] = lsb ? rxb[i][j] : rxb[i][7-j];
    mbits[tot*8] = 1'b0;
    nbits = 0; sdi = mbits[0]; mon_mid = ~m_cfg[4]; mon_on = 1;
    wr(8'h10, 32'(traw & 15) | (32'(xraw & 15) << 8) | (32'(id) << 16) | (32'(leave) << 20));
    cyc = 0;
    reg_addr = 8'h08; #1;
    while (reg_rdata[0] && cyc < 100000) begin
      if (poke && cyc == 5) begin
        reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h0000_0101;
        @(negedge clk); reg_addr = 8'hC0; reg_wdata = 32'h5A;
        @(negedge clk); reg_addr = 8'h00; reg_wdata = 32'h0;
        @(negedge clk); reg_wr = 1'b0; cyc += 3;
        reg_addr = 8'h08; #1;
      end else begin
        cyc++; @(negedge clk); #1;
      end
    end
    mon_on = 0;
    chk(cyc == 16 * div * tot, "R3", "busy duration", cyc, 16 * div * tot);
    chk(nbits == 8 * tot, "R3", "sample edge count", nbits, 8 * tot);
    ok_tx = 1; ok_oe = 1;
    for (int i = 0; i < tot; i++) begin
      sent = '0;
      for (int j = 0; j < 8; j++) begin
        bi = i * 8 + j;
        if (lsb) sent[j] = cap[bi]; else sent[7-j] = cap[bi];
        if (cap_oe[bi] != (tw ? (i < tx) : 1'b1)) ok_oe = 0;
      end
      if (sent != ((i < tx) ? m_slot[i] : 8'h00)) begin
        ok_tx = 0;
        $display("FAIL R6 R5 tx byte %0d: actual %0h expected %0h", i, sent,
                 (i < tx) ? m_slot[i] : 8'h00);
      end
    end
    chk(ok_tx, "R6", "transmitted bytes", ok_tx, 1);
    chk(ok_oe, "R10", "data line enable", ok_oe, 1);
    chk(cs_run == cs_exp(1, id, hi), "R8", "cs during transfer", cs_run, cs_exp(1, id, hi));
    chk(oe_run == m_cfg[15:12], "R8", "cs enables", oe_run, m_cfg[15:12]);
    chk(cs_o == cs_exp(leave, id, hi), "R8", "cs after transfer", cs_o, cs_exp(leave, id, hi));
    chk(sclk == (m_cfg[4] ^ m_cfg[5]), "R4", "sclk idle level", sclk, m_cfg[4] ^ m_cfg[5]);
    for (int i = 0; i < tot; i++) m_slot[i] = rxb[i];
    for (int i = 0; i < 9; i++) begin
      rd(8'h80 + 8'(8 * i), r);
      chk(r[7:0] == m_slot[i], "R7", "slot after transfer", r[7:0], m_slot[i]);
    end
    if (poke) begin
      rd(8'h00, r);
      chk(r == m_cfg, "R9", "config write while busy", r, m_cfg);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4711));
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; sdi = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R1
    chk(cs_o == 4'hF, "R1", "cs levels", cs_o, 4'hF);
    chk(cs_oe == 4'h0, "R1", "cs enables", cs_oe, 0);
    chk(sclk == 1'b0 && mosi_oe == 1'b1, "R1", "sclk/oe", {sclk, mosi_oe}, 2'b01);
    rd(8'h08, r); chk(r == 0, "R1", "status", r, 0);
    rd(8'h00, r); chk(r == 0, "R1", "config", r, 0);
    m_cfg = 0;
    // R2 slot map
    fill_slots();
    for (int i = 0; i < 9; i++) begin
      rd(8'h80 + 8'(8 * i), r);
      chk(r == {24'b0, m_slot[i]}, "R2", "slot readback", r, m_slot[i]);
    end
    // directed: mode 0, MSB first
    set_cfg(mkcfg(2, 4'hF, 0, 0, 0, 0, 0));
    run(3, 3, 1, 0, 0);
    // R6 receive only
    run(2, 0, 2, 0, 0);
    // R3 divider 0, R5 LSB first, CPHA=1
    set_cfg(mkcfg(0, 4'h5, 1, 1, 0, 1, 1));
    fill_slots();
    run(4, 9, 0, 0, 0);
    // R6 total clamp to 9 and zero total
    run(15, 2, 3, 0, 0);
    run(0, 0, 2, 0, 0);
    // R8 hold across commands
    run(2, 2, 1, 1, 0);
    run(1, 1, 1, 0, 0);
    // R10 three-wire
    set_cfg(mkcfg(1, 4'hF, 0, 1, 1, 0, 0));
    run(5, 2, 2, 0, 0);
    // R9 writes while busy
    set_cfg(mkcfg(3, 4'hF, 1, 0, 0, 0, 0));
    run(4, 4, 0, 0, 1);
    // R11 config zero releases held cs
    run(1, 1, 3, 1, 0);
    set_cfg(32'h0); #1;
    chk(cs_oe == 4'h0 && cs_o == 4'hF, "R11", "cs after config clear", {cs_oe, cs_o}, 8'h0F);
    // random
    for (int k = 0; k < 25; k++) begin
      set_cfg(mkcfg(int'($urandom % 4), 4'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 1'($urandom)));
      fill_slots();
      run(int'($urandom % 13), int'($urandom % 13), int'($urandom % 4), 1'($urandom), 0);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule